// File: doc/BRIEF.md
# Latched/Registered Bidirectional Bus Transceiver

This block moves an 18-bit word between two buses, A and B, in both directions. Each direction has its own controls. A transparent latch enable makes the output follow the input. A strobe stores the input on its rising edge, and a clock enable qualifies that strobe. An active-low output enable drives or releases the output. With the latch enable low and no qualified strobe edge, the output holds the last stored word.

Each bidirectional bus is split into an input vector, a data output vector and a per-bit output-enable vector, so the parent can build the tri-state pads. Everything runs on one system clock. Each strobe is treated as an asynchronous level: it is synchronised and its rising edge is detected.

Top module: `bus_xcvr_latreg`

## Requirements
- R1: While `rst_ni` is low, both output-enable vectors are all zero. Reset clears both stored words to zero, so after reset with the latch enables low, `b_o` and `a_o` read zero.
- R2: While `ab_le_i` is high, `b_o` equals `a_i` in the same cycle with no register delay. While `ba_le_i` is high, `a_o` equals `b_i` in the same way.
- R3: While a latch enable is high, the stored word is loaded on every system clock edge. When the latch enable falls, the output keeps the input value seen at the last clock edge before the fall.
- R4: With the latch enable low and the clock enable low, a rising edge on the direction's strobe stores the current input. The new word shows on the output after the third system clock edge that follows the strobe rise: two edges pass through the synchroniser and one edge performs the capture.
- R5: While the clock enable (`*_clken_ni`) is high, strobe edges store nothing and the output is unchanged.
- R6: With the latch enable low, the output holds its stored word when no strobe edge occurs. A strobe held high causes one capture only. A falling strobe edge causes no capture.
- R7: Output enables are active-low. When `ab_oe_ni` is 0, every bit of `b_oe_o` is 1; when it is 1, every bit is 0. `ba_oe_ni` controls `a_oe_o` in the same way.
- R8: Releasing and then re-enabling an output leaves the stored word unchanged, and the held word appears again.
- R9: The B-to-A direction behaves as R2 to R8 describe, using its own controls. Neither direction's controls affect the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | A bus input from the pad |
| a_o | output | 18 | Data driven onto the A bus (B-to-A path) |
| a_oe_o | output | 18 | Per-bit drive enable for the A bus |
| b_i | input | 18 | B bus input from the pad |
| b_o | output | 18 | Data driven onto the B bus (A-to-B path) |
| b_oe_o | output | 18 | Per-bit drive enable for the B bus |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B transparent latch enable |
| ab_strobe_i | input | 1 | A-to-B capture strobe (asynchronous) |
| ab_clken_ni | input | 1 | A-to-B strobe qualifier, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A transparent latch enable |
| ba_strobe_i | input | 1 | B-to-A capture strobe (asynchronous) |
| ba_clken_ni | input | 1 | B-to-A strobe qualifier, active low |

## Verification
The capture assertions assume that the clock enable and the input word stay steady from the strobe rise until the capture edge, because only the strobe passes through the synchroniser. The bench applies every data change and every clock-enable change on a falling clock edge and holds them across each strobe window. The assertions also assume that each strobe pulse stays high for at least one system clock. The bench holds each strobe high for three or more cycles and lets the synchroniser settle before it starts another window.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned DATA_W = 18;
  parameter int unsigned SYNC_STAGES = 2;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/strobe_edge_det.sv
module strobe_edge_det #(
  parameter int unsigned STAGES = xcvr_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= strobe_i;
        else             sync_q[i] <= sync_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t data_i,
  input  logic  le_i,
  input  logic  rise_i,
  input  logic  clken_ni,
  input  logic  oe_ni,
  output word_t data_o,
  output word_t oe_o
);
  word_t store_q;
  logic  load;

  // transparent mode tracks input every cycle so a falling le freezes last value
  assign load = le_i | (rise_i & ~clken_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (load) store_q <= data_i;
  end

  assign data_o = le_i ? data_i : store_q;
  assign oe_o   = rst_ni ? {DATA_W{~oe_ni}} : '0;

  AST_TRACK_IN_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> store_q == $past(data_i)); // R3
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise_i && !clken_ni) |=> store_q == $past(data_i)); // R4
  AST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && clken_ni) |=> $stable(store_q)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i) |=> $stable(store_q)); // R6
  AST_OE_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i && $changed(oe_ni)) |=> $stable(store_q)); // R8
  always_comb begin
    if (!rst_ni) AST_OE_RESET: assert (oe_o == '0); // R1
  end
endmodule

// File: rtl/bus_xcvr_latreg.sv
module bus_xcvr_latreg
  import xcvr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] b_oe_o,
  input  logic              ab_oe_ni,
  input  logic              ab_le_i,
  input  logic              ab_strobe_i,
  input  logic              ab_clken_ni,
  input  logic              ba_oe_ni,
  input  logic              ba_le_i,
  input  logic              ba_strobe_i,
  input  logic              ba_clken_ni
);
  logic ab_rise, ba_rise;

  strobe_edge_det u_ab_edge (.clk_i, .rst_ni, .strobe_i(ab_strobe_i), .rise_o(ab_rise));
  strobe_edge_det u_ba_edge (.clk_i, .rst_ni, .strobe_i(ba_strobe_i), .rise_o(ba_rise));

  xcvr_lane u_ab (
    .clk_i, .rst_ni, .data_i(a_i), .le_i(ab_le_i), .rise_i(ab_rise),
    .clken_ni(ab_clken_ni), .oe_ni(ab_oe_ni), .data_o(b_o), .oe_o(b_oe_o)
  );
  xcvr_lane u_ba (
    .clk_i, .rst_ni, .data_i(b_i), .le_i(ba_le_i), .rise_i(ba_rise),
    .clken_ni(ba_clken_ni), .oe_ni(ba_oe_ni), .data_o(a_o), .oe_o(a_oe_o)
  );

  AST_OE_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o == {DATA_W{~ab_oe_ni}}) && (a_oe_o == {DATA_W{~ba_oe_ni}})); // R7
  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i |-> b_o == a_i) and (ba_le_i |-> a_o == b_i)); // R2 R9
endmodule

// File: tb/bus_xcvr_latreg_test.sv
module bus_xcvr_latreg_test;
  localparam int W = 18;
  logic clk = 0, rst_ni = 0;
  logic [W-1:0] a_i = '0, b_i = '0, a_o, b_o, a_oe_o, b_oe_o;
  logic ab_oe_ni = 1, ab_le_i = 0, ab_strobe_i = 0, ab_clken_ni = 1;
  logic ba_oe_ni = 1, ba_le_i = 0, ba_strobe_i = 0, ba_clken_ni = 1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bus_xcvr_latreg uut (.clk_i(clk), .rst_ni, .a_i, .a_o, .a_oe_o, .b_i, .b_o, .b_oe_o,
    .ab_oe_ni, .ab_le_i, .ab_strobe_i, .ab_clken_ni,
    .ba_oe_ni, .ba_le_i, .ba_strobe_i, .ba_clken_ni);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe rise at negedge; capture lands on third posedge after it
  task automatic pulse_ab;
    ab_strobe_i = 1; cyc(3); #1;
  endtask
  task automatic end_ab;
    ab_strobe_i = 0; cyc(3);
  endtask
  task automatic pulse_ba;
    ba_strobe_i = 1; cyc(3); #1;
  endtask
  task automatic end_ba;
    ba_strobe_i = 0; cyc(3);
  endtask

  function automatic logic [W-1:0] pat(input int k);
    if (k < W) return W'(1) << k;
    return {W{1'b1}} ^ (W'(k * 40503) ^ W'(k << 7));
  endfunction

  initial begin
    logic [W-1:0] held;
    cyc(2); #1;
    chk("R1 b_oe in reset", b_oe_o, '0);
    chk("R1 a_oe in reset", a_oe_o, '0);
    ab_oe_ni = 0; ba_oe_ni = 0; #1;
    chk("R1 b_oe forced low in reset", b_oe_o, '0);
    @(negedge clk); rst_ni = 1; #1;
    chk("R1 b_o cleared", b_o, '0);
    chk("R1 a_o cleared", a_o, '0);
    chk("R7 b_oe on", b_oe_o, '1);
    chk("R7 a_oe on", a_oe_o, '1);

    // R2 transparent sweep, both directions
    ab_le_i = 1; ba_le_i = 1;
    for (int k = 0; k < W + 8; k++) begin
      @(negedge clk); a_i = pat(k); b_i = ~pat(k); #1;
      chk("R2 a->b transparent", b_o, pat(k));
      chk("R9 b->a transparent", a_o, ~pat(k));
    end
    // R3 freeze on latch-enable fall
    @(negedge clk); a_i = 18'h2A5C3; b_i = 18'h15A3C;
    @(negedge clk); ab_le_i = 0; ba_le_i = 0; a_i = 18'h3FFFF; b_i = 18'h00001; #1;
    chk("R3 a->b freeze", b_o, 18'h2A5C3);
    chk("R9 b->a freeze", a_o, 18'h15A3C);
    cyc(4); #1;
    chk("R6 a->b hold no edge", b_o, 18'h2A5C3);

    // R4 capture sweep A->B
    ab_clken_ni = 0;
    for (int k = 0; k < W + 4; k++) begin
      @(negedge clk); a_i = pat(k) ^ 18'h0F0F0;
      held = a_i;
      ab_strobe_i = 1; cyc(2); #1;
      chk("R4 no early capture", b_o, k == 0 ? 18'h2A5C3 : pat(k-1) ^ 18'h0F0F0);
      cyc(1); #1;
      chk("R4 a->b capture", b_o, held);
      @(negedge clk); a_i = ~held; cyc(3); #1;
      chk("R6 strobe held high one capture", b_o, held);
      end_ab; #1;
      chk("R6 falling strobe no capture", b_o, held);
    end
    // R5 gating
    ab_clken_ni = 1; a_i = 18'h12345;
    pulse_ab;
    chk("R5 a->b gated", b_o, held);
    end_ab;
    // R8 disable/re-enable
    ab_oe_ni = 1; #1;
    chk("R7 b_oe off", b_oe_o, '0);
    cyc(3); ab_oe_ni = 0; #1;
    chk("R8 held after re-enable", b_o, held);
    chk("R7 b_oe back on", b_oe_o, '1);

    // R9 B->A capture, gating, independence
    ba_clken_ni = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); b_i = pat(k + 3) ^ 18'h33333; held = b_i;
      pulse_ba;
      chk("R9 b->a capture", a_o, held);
      chk("R9 a->b untouched", b_o, pat(W + 3) ^ 18'h0F0F0);
      end_ba;
    end
    ba_clken_ni = 1; b_i = 18'h0BEEF;
    pulse_ba;
    chk("R9 b->a gated", a_o, held);
    end_ba;
    ba_oe_ni = 1; #1;
    chk("R9 a_oe off", a_oe_o, '0);
    ba_oe_ni = 0; #1;
    chk("R9 held after re-enable", a_o, held);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule